// File: doc/BRIEF.md
# Two-Wire EEPROM Bit-Bang Port

This block gives a CPU direct, bit-level control of a two-wire serial EEPROM. One write register holds three control bits: the level asked of the serial clock line, the level asked of the serial data line, and a direction bit. When the direction bit is set, the data line is released so the device can drive it. A wide read window in the CPU's memory map returns the level on the data line at one bit position. The other seven bits are left undriven, so the bus keeps its previous value on those bits.

Both serial lines are open-drain. The block never drives a line high. It only asserts a pull-low request, and an external pull-up supplies the high level. The data line is sampled through a synchronizer, and a read reports the level actually present on the pin. That level may be low because the EEPROM is pulling it down, even while the block has released it. A presence parameter removes the port entirely for boards that have no EEPROM.

Software builds every start, stop, clock pulse and acknowledge itself, one register write at a time. The block does no serial sequencing of its own.

Top module: `eep_bitbang_port`

## Requirements
- R1: While reset is high and in the cycle after it, both pull-low outputs are 0 (lines released), the data output enable is 0 and the direction bit is 0.
- R2: A write takes effect only when address bit 15 is 1 and address bits 3:0 equal 4'hD. Bits 14:4 are ignored. Writes to any other address leave both pull-low outputs unchanged.
- R3: After an accepted write, the clock pull-low output equals the inverse of data bit 5 (0 pulls the line low, 1 releases it).
- R4: After an accepted write with data bit 7 = 0, the data pull-low output equals the inverse of data bit 6.
- R5: After an accepted write with data bit 7 = 1 (read direction), the data line is released whatever the value of data bit 6.
- R6: A read (rw = 1, m2 = 1) with address bits 15:13 = 3'b011 sets the data output enable to 8'h10 on the next clock edge. Data bit 4 then carries the synchronized data-pin level.
- R7: For reads outside that window, and for all writes, the data output enable is 8'h00, so the bus is left floating.
- R8: With the presence parameter cleared, the pull-low outputs and the data output enable stay 0 whatever the bus does.
- R9: A write cycle is accepted only while m2 = 1 and rw = 0. The same address and data with m2 = 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the CPU bus |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_din | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU phase-2 strobe, bus valid when 1 |
| sda_pin | input | 1 | Level sensed on the serial data line |
| cpu_dout | output | 8 | Read data, meaningful only where the enable is set |
| cpu_doe | output | 8 | Per-bit output enable for the CPU data bus |
| scl_pull_low | output | 1 | 1 = pull the serial clock line low |
| sda_pull_low | output | 1 | 1 = pull the serial data line low |

## Verification
The hardest case to reach is a read that returns 0 while the block itself has released the data line. This is the acknowledge and read-data case, where only the external device holds the line down. The bench models an EEPROM pulling the line low on its own, and a pull-up that gives the wired-AND of both drivers. It then sweeps direction bit, requested data level and device pull across a spread of window addresses. Every expected bit is derived arithmetically from those three inputs.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam logic [3:0] CTRL_NIBBLE = 4'hD;
  localparam logic [2:0] READ_WINDOW = 3'b011;
  localparam int SCL_BIT  = 5;
  localparam int SDA_BIT  = 6;
  localparam int DIR_BIT  = 7;
  localparam int RD_BIT   = 4;

  typedef struct packed {
    logic dir_in;
    logic sda_req;
    logic scl_req;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{dir_in: 1'b0, sda_req: 1'b1, scl_req: 1'b1};
endpackage

// File: rtl/eep_bus_decode.sv
module eep_bus_decode
  import eep_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              m2,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic cycle_valid;
  assign cycle_valid = m2;
  assign wr_hit = cycle_valid && !rw && addr[ADDR_W-1] && (addr[3:0] == CTRL_NIBBLE);
  assign rd_hit = cycle_valid && rw && (addr[ADDR_W-1 -: 3] == READ_WINDOW);
endmodule

// File: rtl/eep_ctrl_reg.sv
module eep_ctrl_reg
  import eep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RESET;
    end else if (wr_en) begin
      ctrl.dir_in  <= wdata[DIR_BIT];
      ctrl.sda_req <= wdata[SDA_BIT];
      ctrl.scl_req <= wdata[SCL_BIT];
    end
  end
endmodule

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], pin};
  end
  assign level = chain[STAGES-1];
endmodule

// File: rtl/eep_read_port.sv
module eep_read_port
  import eep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic              sda_level,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] doe
);
  localparam logic [DATA_W-1:0] RD_MASK = DATA_W'(1) << RD_BIT;
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      doe  <= '0;
    end else begin
      doe  <= rd_hit ? RD_MASK : '0;
      dout <= rd_hit ? (sda_level ? RD_MASK : '0) : '0;
    end
  end
endmodule

// File: rtl/eep_bitbang_port.sv
module eep_bitbang_port
  import eep_pkg::*;
#(
  parameter bit HAS_EEPROM  = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_din,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic              sda_pin,
  output logic [DATA_W-1:0] cpu_dout,
  output logic [DATA_W-1:0] cpu_doe,
  output logic              scl_pull_low,
  output logic              sda_pull_low
);
  generate
    if (HAS_EEPROM) begin : g_port
      logic  wr_hit, rd_hit, sda_level;
      ctrl_t ctrl;

      eep_bus_decode u_dec (
        .addr(cpu_addr), .rw(cpu_rw), .m2(cpu_m2),
        .wr_hit(wr_hit), .rd_hit(rd_hit)
      );
      eep_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_hit), .wdata(cpu_din), .ctrl(ctrl)
      );
      eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(sda_pin), .level(sda_level)
      );
      eep_read_port u_rd (
        .clk(clk), .rst(rst), .rd_hit(rd_hit), .sda_level(sda_level),
        .dout(cpu_dout), .doe(cpu_doe)
      );
      assign scl_pull_low = !ctrl.scl_req;
      assign sda_pull_low = !ctrl.dir_in && !ctrl.sda_req;
    end else begin : g_absent
      assign cpu_dout     = '0;
      assign cpu_doe      = '0;
      assign scl_pull_low = 1'b0;
      assign sda_pull_low = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/eep_bitbang_port_chk.sv
module eep_bitbang_port_chk
  import eep_pkg::*;
#(
  parameter bit HAS_EEPROM = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_din,
  input logic              cpu_rw,
  input logic              cpu_m2,
  input logic [DATA_W-1:0] cpu_doe,
  input logic              scl_pull_low,
  input logic              sda_pull_low
);
  logic wr_cyc, rd_win;
  assign wr_cyc = cpu_m2 && !cpu_rw && cpu_addr[15] && (cpu_addr[3:0] == 4'hD);
  assign rd_win = cpu_m2 && cpu_rw && (cpu_addr[15:13] == 3'b011);

  // R1
  p_released_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!scl_pull_low && !sda_pull_low && cpu_doe == '0));

  // R6
  p_oe_single_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_doe == 8'h00) || (cpu_doe == 8'h10));

  // R7
  p_oe_needs_window_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_doe != 8'h00) |-> $past(rd_win));

  generate
    if (HAS_EEPROM) begin : g_on
      // R2, R9
      p_no_write_no_change_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_cyc |=> ($stable(scl_pull_low) && $stable(sda_pull_low)));
      // R3
      p_scl_follows_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_cyc |=> (scl_pull_low == !$past(cpu_din[5])));
      // R4, R5
      p_sda_follows_write_r4: assert property (@(posedge clk) disable iff (rst)
        wr_cyc |=> (sda_pull_low == (!$past(cpu_din[7]) && !$past(cpu_din[6]))));
      // R6
      p_window_enables_r6: assert property (@(posedge clk) disable iff (rst)
        rd_win |=> (cpu_doe == 8'h10));
    end else begin : g_off
      // R8
      always_comb begin
        a_absent_quiet_r8: assert (!scl_pull_low && !sda_pull_low && cpu_doe == '0);
      end
    end
  endgenerate
endmodule

bind eep_bitbang_port eep_bitbang_port_chk #(.HAS_EEPROM(HAS_EEPROM)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
  .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .cpu_doe(cpu_doe),
  .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
);

// File: tb/eep_bitbang_port_bench.sv
module eep_bitbang_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  din = 8'h00;
  logic        rw = 1'b1;
  logic        m2 = 1'b0;
  logic        dev_low = 1'b0;
  logic [7:0]  dout, doe, dout_x, doe_x;
  logic        scl_pl, sda_pl, scl_x, sda_x;
  logic        sda_wire;
  int          n_chk = 0, n_bad = 0;
  logic        exp_scl, exp_sda;

  always #2.5 clk = ~clk;

  assign sda_wire = !(sda_pl || dev_low);

  eep_bitbang_port u_eep_bitbang_port (
    .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_din(din), .cpu_rw(rw),
    .cpu_m2(m2), .sda_pin(sda_wire), .cpu_dout(dout), .cpu_doe(doe),
    .scl_pull_low(scl_pl), .sda_pull_low(sda_pl)
  );

  eep_bitbang_port #(.HAS_EEPROM(1'b0)) u_absent (
    .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_din(din), .cpu_rw(rw),
    .cpu_m2(m2), .sda_pin(dev_low), .cpu_dout(dout_x), .cpu_doe(doe_x),
    .scl_pull_low(scl_x), .sda_pull_low(sda_x)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic r, input logic strobe);
    @(negedge clk);
    addr = a; din = d; rw = r; m2 = strobe;
    @(negedge clk);
    m2 = 1'b0; rw = 1'b1;
  endtask

  task automatic chk_lines(input string req);
    check({req, " scl"}, {31'd0, scl_pl}, {31'd0, exp_scl});
    check({req, " sda"}, {31'd0, sda_pl}, {31'd0, exp_sda});
    check("R8 absent quiet", {scl_x, sda_x, doe_x}, 10'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 scl", {31'd0, scl_pl}, 0);
    check("R1 sda", {31'd0, sda_pl}, 0);
    check("R1 doe", {24'd0, doe}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 post scl", {31'd0, scl_pl}, 0);
    check("R1 post doe", {24'd0, doe}, 0);
    exp_scl = 1'b0; exp_sda = 1'b0;

    // R3 R4 R5: sweep all control bit combinations at several aliases
    for (int a = 0; a < 4; a++) begin
      for (int c = 0; c < 8; c++) begin
        logic [15:0] wa;
        logic [7:0]  wd;
        wa = 16'h800D | (16'(a) * 16'h1230 & 16'h7FF0);
        wd = {3'(c), 5'(a * 7 + c)};
        bus(wa, wd, 1'b0, 1'b1);
        exp_scl = !wd[5];
        exp_sda = !wd[7] && !wd[6];
        chk_lines(wd[7] ? "R5" : "R3/R4");
        check("R7 doe on write", {24'd0, doe}, 0);
      end
    end

    // R2: decode misses leave lines unchanged (set both low first)
    bus(16'h800D, 8'h00, 1'b0, 1'b1);
    exp_scl = 1'b1; exp_sda = 1'b1;
    for (int n = 0; n < 16; n++) begin
      if (n != 13) begin
        bus(16'h8000 | 16'(n), 8'hE0, 1'b0, 1'b1);
        chk_lines("R2 nibble miss");
      end
    end
    bus(16'h700D, 8'hE0, 1'b0, 1'b1);
    chk_lines("R2 a15 low");
    // R9: no strobe, or read direction
    bus(16'h800D, 8'hE0, 1'b0, 1'b0);
    chk_lines("R9 m2 low");
    bus(16'h800D, 8'hE0, 1'b1, 1'b1);
    chk_lines("R9 rw high");

    // R6: read window, sweep dir / data request / device pull
    for (int c = 0; c < 8; c++) begin
      logic dirb, sdab, pull, lvl;
      dirb = c[0]; sdab = c[1]; pull = c[2];
      dev_low = pull;
      bus(16'hBFFD, {dirb, sdab, 6'b100000}, 1'b0, 1'b1);
      lvl = !((!dirb && !sdab) || pull);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        addr = 16'h6000 + 16'(k) * 16'h07FF; rw = 1'b1; m2 = 1'b1;
        @(negedge clk);
        check("R6 doe", {24'd0, doe}, 32'h10);
        check("R6 bit4", {31'd0, dout[4]}, {31'd0, lvl});
        check("R8 absent doe", {24'd0, doe_x}, 0);
        m2 = 1'b0;
      end
    end
    dev_low = 1'b0;

    // R7: reads outside the window
    for (int k = 0; k < 8; k++) begin
      logic [15:0] ra;
      ra = (k < 4) ? (16'h0000 + 16'(k) * 16'h1FFF) : (16'h8000 + 16'(k - 4) * 16'h2001);
      if (ra[15:13] == 3'b011) ra = 16'h5FFF;
      @(negedge clk);
      addr = ra; rw = 1'b1; m2 = 1'b1;
      @(negedge clk);
      check("R7 doe outside", {24'd0, doe}, 0);
      m2 = 1'b0;
    end
    // R7: window read with m2 low
    @(negedge clk); addr = 16'h6123; rw = 1'b1; m2 = 1'b0;
    @(negedge clk);
    check("R7 doe m2 low", {24'd0, doe}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
    $finish;
  end
endmodule